// File: doc/BRIEF.md
# Cascaded Sixteen-Line Priority Interrupt Controller

This block joins two eight-line priority interrupt units into one sixteen-line controller. The second unit (lines 8 to 15) does not reach the processor directly. Its interrupt output is the request for input 2 of the first unit (lines 0 to 7). The request pin for line 2 is therefore reserved. Each unit keeps three registers of its own: a mask, a pending-request register and an in-service register. The processor sees one interrupt output. It claims the winning line with a one-cycle acknowledge strobe and reads the 4-bit line number that the block presents during that strobe.

Because the whole second unit sits on input 2, the resulting priority order is 0, 1, 8 to 15, then 3 to 7. A line that is in service blocks only itself and lines ranked below it, so a more urgent line can still nest on top of it. The two units take separate non-specific end-of-interrupt strobes. A line from the second unit therefore needs one strobe on each unit. A request that is withdrawn before its acknowledge produces a spurious report: number 7 from the first unit, or number 15 from the second. The in-service outputs let software tell a spurious report from a real one.

Top module: `cascade_pic`

## Requirements
- R1: A synchronous reset sets both masks to all ones and clears every pending and in-service bit. While both masks stay set, `int_o` stays low and the in-service outputs stay zero, even with every request input high.
- R2: A request on an unmasked idle line raises `int_o`. For lines 0 to 7 this happens after one rising edge; for lines 8 to 15 it takes two edges, because the second unit's output is registered again on input 2. During `ack_i`, `ack_vec_o` gives the winning line as a binary number from 0 to 15.
- R3: When several requests are pending, the acknowledge returns the line with the highest rank. Ranks run, highest first: 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R4: While a line is in service, `int_o` rises for a new request only if that request outranks every line in service. A new request of equal or lower rank does not raise it.
- R5: Mask bits are active high. Bit i of the first mask blocks line i, and bit 2 of that mask blocks all of lines 8 to 15. Bit i of the second mask blocks line 8+i. A write lands on the edge where its strobe is high.
- R6: An acknowledge sets exactly the winner's in-service bit in the same edge. A winner from 8 to 15 sets bit 2 of `pri_isr_o` and bit (line-8) of `sec_isr_o`.
- R7: An end-of-interrupt strobe clears the lowest-numbered set in-service bit of its own unit and does nothing when that unit has no bit set. A line from 8 to 15 is fully retired only after both strobes.
- R8: An acknowledge while the first unit has no eligible request returns 7 and sets no in-service bit.
- R9: An acknowledge that passes through input 2 while the second unit has no eligible request returns 15. It sets bit 2 of `pri_isr_o` and no bit of `sec_isr_o`.
- R10: The level on `irq_i[2]` never affects `int_o`, `ack_vec_o` or either in-service output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_i | input | 16 | Level request lines; bit 2 is reserved |
| pri_mask_we_i | input | 1 | Write strobe for the first unit's mask |
| sec_mask_we_i | input | 1 | Write strobe for the second unit's mask |
| mask_wdata_i | input | 8 | Mask value to write |
| int_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| ack_vec_o | output | 4 | Winning line number while `ack_i` is high, otherwise zero |
| eoi_pri_i | input | 1 | Non-specific end-of-interrupt to the first unit |
| eoi_sec_i | input | 1 | Non-specific end-of-interrupt to the second unit |
| pri_isr_o | output | 8 | In-service bits of the first unit |
| sec_isr_o | output | 8 | In-service bits of the second unit |

## Verification
The bench runs every ordered pair of distinct usable lines twice. The first sweep raises both lines together and checks that the acknowledge picks the higher rank. A design that used plain numeric order would hand line 3 ahead of line 9. The second sweep puts one line in service and raises the other. A design that blocked every line during service, or that let the cascade input be blocked by its own in-service bit, would hold off a higher-ranked secondary line. The bench then withdraws requests just before an acknowledge to provoke both spurious reports. A design that set in-service bits on a spurious report would leave stray bits in the in-service outputs. It also checks that an end-of-interrupt to one unit leaves the other unit untouched.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Lines per unit and the first-unit input that carries the second unit.
    localparam int unsigned DEF_UNIT_LINES  = 8;
    localparam int unsigned DEF_CASCADE_IDX = 2;

    // Outcome of an acknowledge cycle, decoded at the top level.
    typedef enum logic [1:0] {
        ACK_IDLE     = 2'd0,
        ACK_DIRECT   = 2'd1,
        ACK_CHAINED  = 2'd2,
        ACK_SPURIOUS = 2'd3
    } ack_kind_e;

endpackage

// File: rtl/cic_first_set.sv
// Lowest-numbered set bit of a vector; lower index means higher priority.
module cic_first_set #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/cic_unit.sv
// One eight-line unit: mask, pending and in-service registers plus resolution.
module cic_unit #(
    parameter int unsigned N        = cic_pkg::DEF_UNIT_LINES,
    parameter int unsigned IW       = $clog2(N),
    parameter bit          CASC_EN  = 1'b0,
    parameter int unsigned CASC_IDX = cic_pkg::DEF_CASCADE_IDX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          mask_we_i,
    input  logic [N-1:0]  mask_wdata_i,
    input  logic          ack_i,
    input  logic          eoi_i,
    output logic          win_valid_o,
    output logic [IW-1:0] win_idx_o,
    output logic [N-1:0]  isr_o
);

    typedef logic [N-1:0] line_t;

    typedef struct packed {
        line_t mask;
        line_t irr;
        line_t isr;
    } unit_state_t;

    // The cascade input stays requestable while its own bit is in service:
    // the downstream unit resolves nesting among its lines itself.
    localparam line_t CASC_BIT  = CASC_EN ? (line_t'(1) << CASC_IDX) : '0;
    localparam line_t GATE_KEEP = ~CASC_BIT;

    localparam unit_state_t RESET_STATE = '{mask: '1, irr: '0, isr: '0};

    unit_state_t state_q, state_d;

    logic          pend_v, svc_v, top_v;
    logic [IW-1:0] pend_idx, svc_idx, top_idx;
    logic          casc_reentry;
    line_t         set_vec, clr_vec;

    cic_first_set #(.N(N), .IW(IW)) u_pend (
        .vec_i   (state_q.irr),
        .found_o (pend_v),
        .idx_o   (pend_idx)
    );

    cic_first_set #(.N(N), .IW(IW)) u_svc (
        .vec_i   (state_q.isr),
        .found_o (svc_v),
        .idx_o   (svc_idx)
    );

    // Same vector as u_svc: the end-of-interrupt target is the top in-service bit.
    assign top_v   = svc_v;
    assign top_idx = svc_idx;

    // Equal priority is blocked, except the cascade input re-entering itself.
    assign casc_reentry = CASC_EN && (pend_idx == IW'(CASC_IDX)) && (svc_idx == IW'(CASC_IDX));

    assign win_valid_o = pend_v && (!svc_v || (pend_idx < svc_idx) || casc_reentry);
    assign win_idx_o   = pend_idx;
    assign isr_o       = state_q.isr;

    always_comb begin
        state_d = state_q;

        if (mask_we_i) begin
            state_d.mask = mask_wdata_i;
        end

        clr_vec = (eoi_i && top_v) ? (line_t'(1) << top_idx) : '0;
        set_vec = (ack_i && win_valid_o) ? (line_t'(1) << pend_idx) : '0;

        state_d.isr = (state_q.isr & ~clr_vec) | set_vec;
        // Level-following request register, gated by mask and service state.
        state_d.irr = req_i & ~state_q.mask & ~(state_d.isr & GATE_KEEP) & ~set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/cascade_pic.sv
// Two cascaded eight-line priority units presenting sixteen request lines.
module cascade_pic #(
    parameter int unsigned LINES    = cic_pkg::DEF_UNIT_LINES,
    parameter int unsigned CASC_IDX = cic_pkg::DEF_CASCADE_IDX
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*LINES-1:0]            irq_i,
    input  logic                          pri_mask_we_i,
    input  logic                          sec_mask_we_i,
    input  logic [LINES-1:0]              mask_wdata_i,
    output logic                          int_o,
    input  logic                          ack_i,
    output logic [$clog2(2*LINES)-1:0]    ack_vec_o,
    input  logic                          eoi_pri_i,
    input  logic                          eoi_sec_i,
    output logic [LINES-1:0]              pri_isr_o,
    output logic [LINES-1:0]              sec_isr_o
);

    import cic_pkg::*;

    localparam int unsigned IW    = $clog2(LINES);
    localparam int unsigned VEC_W = $clog2(2 * LINES);

    logic [LINES-1:0] pri_req;
    logic             pri_win_v, sec_win_v;
    logic [IW-1:0]    pri_win_idx, sec_win_idx;
    logic             sec_ack;
    ack_kind_e        ack_kind;

    // First-unit request vector: the cascade slot takes the second unit's output.
    for (genvar g = 0; g < LINES; g++) begin : g_pri_req
        if (g == CASC_IDX) begin : g_casc
            // The pin at this position is reserved; its level is discarded.
            assign pri_req[g] = sec_win_v | (irq_i[g] & 1'b0);
        end else begin : g_direct
            assign pri_req[g] = irq_i[g];
        end
    end

    cic_unit #(
        .N        (LINES),
        .IW       (IW),
        .CASC_EN  (1'b1),
        .CASC_IDX (CASC_IDX)
    ) u_pri (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (pri_req),
        .mask_we_i    (pri_mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .ack_i        (ack_i),
        .eoi_i        (eoi_pri_i),
        .win_valid_o  (pri_win_v),
        .win_idx_o    (pri_win_idx),
        .isr_o        (pri_isr_o)
    );

    cic_unit #(
        .N        (LINES),
        .IW       (IW),
        .CASC_EN  (1'b0),
        .CASC_IDX (CASC_IDX)
    ) u_sec (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (irq_i[2*LINES-1:LINES]),
        .mask_we_i    (sec_mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .ack_i        (sec_ack),
        .eoi_i        (eoi_sec_i),
        .win_valid_o  (sec_win_v),
        .win_idx_o    (sec_win_idx),
        .isr_o        (sec_isr_o)
    );

    assign int_o   = pri_win_v;
    assign sec_ack = ack_i && pri_win_v && (pri_win_idx == IW'(CASC_IDX));

    always_comb begin
        if (!ack_i) begin
            ack_kind = ACK_IDLE;
        end else if (!pri_win_v) begin
            ack_kind = ACK_SPURIOUS;
        end else if (pri_win_idx == IW'(CASC_IDX)) begin
            ack_kind = ACK_CHAINED;
        end else begin
            ack_kind = ACK_DIRECT;
        end
    end

    always_comb begin
        unique case (ack_kind)
            ACK_IDLE:     ack_vec_o = '0;
            ACK_SPURIOUS: ack_vec_o = VEC_W'(LINES - 1);
            ACK_DIRECT:   ack_vec_o = VEC_W'(pri_win_idx);
            ACK_CHAINED:  ack_vec_o = sec_win_v ? (VEC_W'(LINES) + VEC_W'(sec_win_idx))
                                                : VEC_W'(2 * LINES - 1);
            default:      ack_vec_o = '0;
        endcase
    end

endmodule

// File: rtl/cascade_pic_chk.sv
module cascade_pic_chk #(
    parameter int unsigned LINES    = cic_pkg::DEF_UNIT_LINES,
    parameter int unsigned CASC_IDX = cic_pkg::DEF_CASCADE_IDX
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       int_o,
    input logic                       ack_i,
    input logic [$clog2(2*LINES)-1:0] ack_vec_o,
    input logic                       eoi_pri_i,
    input logic                       eoi_sec_i,
    input logic [LINES-1:0]           pri_isr_o,
    input logic [LINES-1:0]           sec_isr_o
);

    AST_ACK_SETS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !eoi_pri_i) |=> ($countones(pri_isr_o & ~$past(pri_isr_o)) <= 1)); // R6

    AST_CHAINED_MARKS_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && (ack_vec_o >= LINES) && !eoi_pri_i) |=> pri_isr_o[CASC_IDX]); // R9

    AST_EOI_CLEARS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pri_i && !ack_i) |=> (($countones($past(pri_isr_o) & ~pri_isr_o) <= 1)
                                   && ((pri_isr_o & ~$past(pri_isr_o)) == '0))); // R7

    AST_ISR_HOLDS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !eoi_pri_i && !eoi_sec_i) |=> ($stable(pri_isr_o) && $stable(sec_isr_o))); // R6

    AST_SPURIOUS_SETS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o && !eoi_pri_i && !eoi_sec_i)
        |=> ($stable(pri_isr_o) && $stable(sec_isr_o) && ($past(ack_vec_o) == LINES - 1))); // R8

endmodule

bind cascade_pic cascade_pic_chk #(.LINES(LINES), .CASC_IDX(CASC_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_o     (int_o),
    .ack_i     (ack_i),
    .ack_vec_o (ack_vec_o),
    .eoi_pri_i (eoi_pri_i),
    .eoi_sec_i (eoi_sec_i),
    .pri_isr_o (pri_isr_o),
    .sec_isr_o (sec_isr_o)
);

// File: tb/cascade_pic_tb.sv
`timescale 1ns/1ps
module cascade_pic_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq;
    logic        pri_we, sec_we;
    logic [7:0]  mask_wd;
    logic        int_o;
    logic        ack;
    logic [3:0]  vec;
    logic        eoi_pri, eoi_sec;
    logic [7:0]  pri_isr, sec_isr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cascade_pic u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_i         (irq),
        .pri_mask_we_i (pri_we),
        .sec_mask_we_i (sec_we),
        .mask_wdata_i  (mask_wd),
        .int_o         (int_o),
        .ack_i         (ack),
        .ack_vec_o     (vec),
        .eoi_pri_i     (eoi_pri),
        .eoi_sec_i     (eoi_sec),
        .pri_isr_o     (pri_isr),
        .sec_isr_o     (sec_isr)
    );

    function automatic int rank(input int l);
        if (l < 2)       return l;
        else if (l >= 8) return l - 6;
        else             return l + 7;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_masks(input logic [7:0] p, input logic [7:0] s);
        @(negedge clk); pri_we = 1'b1; mask_wd = p;
        @(negedge clk); pri_we = 1'b0; sec_we = 1'b1; mask_wd = s;
        @(negedge clk); sec_we = 1'b0;
    endtask

    task automatic do_ack(output logic [3:0] v);
        @(negedge clk); ack = 1'b1;
        #1 v = vec;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic eoi(input logic p, input logic s);
        @(negedge clk); eoi_pri = p; eoi_sec = s;
        @(negedge clk); eoi_pri = 1'b0; eoi_sec = 1'b0;
    endtask

    task automatic clear_all();
        irq = '0;
        tick(3);
        repeat (2) eoi(1'b1, 1'b1);
        tick(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] v;
        irq = '0; pri_we = 0; sec_we = 0; mask_wd = '0;
        ack = 0; eoi_pri = 0; eoi_sec = 0; rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;

        // R1: everything masked after reset
        irq = 16'hFFFF;
        tick(4);
        check(int_o == 1'b0, "R1 int masked", int_o, 0);
        check(pri_isr == 8'h00 && sec_isr == 8'h00, "R1 isr zero", {pri_isr, sec_isr}, 0);
        irq = '0;
        tick(2);
        wr_masks(8'h00, 8'h00);

        // R2 R6 R7: single line latency, vector, in-service bits, EOI sequencing
        for (int l = 0; l < 16; l++) begin
            if (l == 2) continue;
            irq = 16'(1) << l;
            tick(1);
            check(int_o == (l < 8), "R2 first-edge int", int_o, (l < 8));
            tick(1);
            check(int_o == 1'b1, "R2 int raised", int_o, 1);
            do_ack(v);
            check(v == 4'(l), "R2 ack vector", v, l);
            check(pri_isr == ((l < 8) ? 8'(1) << l : 8'h04), "R6 pri isr", pri_isr,
                  (l < 8) ? (1 << l) : 4);
            check(sec_isr == ((l >= 8) ? 8'(1) << (l - 8) : 8'h00), "R6 sec isr", sec_isr,
                  (l >= 8) ? (1 << (l - 8)) : 0);
            irq = '0;
            if (l >= 8) begin
                eoi(1'b0, 1'b1);
                check(sec_isr == 8'h00 && pri_isr == 8'h04, "R7 sec eoi only",
                      {pri_isr, sec_isr}, 16'h0400);
            end
            eoi(1'b1, 1'b0);
            check(pri_isr == 8'h00 && sec_isr == 8'h00, "R7 fully retired",
                  {pri_isr, sec_isr}, 0);
            tick(2);
        end

        // R3: every ordered pair pending together
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                if (a == 2 || b == 2 || a == b) continue;
                irq = (16'(1) << a) | (16'(1) << b);
                tick(4);
                do_ack(v);
                check(v == 4'((rank(a) < rank(b)) ? a : b), "R3 winner", v,
                      (rank(a) < rank(b)) ? a : b);
                clear_all();
            end
        end

        // R4: nesting against every in-service line
        for (int s = 0; s < 16; s++) begin
            for (int n = 0; n < 16; n++) begin
                if (s == 2 || n == 2 || s == n) continue;
                irq = 16'(1) << s;
                tick(4);
                do_ack(v);
                irq = 16'(1) << n;
                tick(4);
                check(int_o == (rank(n) < rank(s)), "R4 nesting", int_o, (rank(n) < rank(s)));
                clear_all();
            end
        end

        // R5: each line blocked by its own mask bit
        for (int l = 0; l < 16; l++) begin
            if (l == 2) continue;
            if (l < 8) wr_masks(8'(1) << l, 8'h00);
            else       wr_masks(8'h00, 8'(1) << (l - 8));
            irq = 16'(1) << l;
            tick(4);
            check(int_o == 1'b0, "R5 own mask", int_o, 0);
            irq = '0;
            tick(2);
        end
        wr_masks(8'h04, 8'h00);
        irq = 16'h0400;
        tick(4);
        check(int_o == 1'b0, "R5 cascade mask", int_o, 0);
        irq = '0;
        wr_masks(8'h00, 8'h00);
        tick(2);

        // R10: reserved pin ignored
        irq = 16'h0004;
        tick(4);
        check(int_o == 1'b0, "R10 reserved pin int", int_o, 0);
        do_ack(v);
        check(v == 4'd7, "R10 reserved pin vector", v, 7);
        check(pri_isr == 8'h00 && sec_isr == 8'h00, "R10 reserved pin isr",
              {pri_isr, sec_isr}, 0);
        irq = '0;
        tick(2);

        // R8: primary request withdrawn before acknowledge
        irq = 16'h0020;
        tick(2);
        check(int_o == 1'b1, "R8 int before withdraw", int_o, 1);
        irq = '0;
        tick(1);
        do_ack(v);
        check(v == 4'd7, "R8 spurious vector", v, 7);
        check(pri_isr == 8'h00 && sec_isr == 8'h00, "R8 no isr", {pri_isr, sec_isr}, 0);
        tick(2);

        // R9: secondary request withdrawn while the cascade request is still registered
        irq = 16'h1000;
        tick(3);
        check(int_o == 1'b1, "R9 int before withdraw", int_o, 1);
        irq = '0;
        do_ack(v);
        check(v == 4'd15, "R9 spurious vector", v, 15);
        check(pri_isr == 8'h04, "R9 cascade bit", pri_isr, 4);
        check(sec_isr == 8'h00, "R9 no sec bit", sec_isr, 0);
        eoi(1'b1, 1'b0);
        check(pri_isr == 8'h00, "R9 single eoi", pri_isr, 0);
        tick(2);

        // R7: highest in-service cleared first, empty unit unaffected
        irq = 16'h0020;
        tick(3);
        do_ack(v);
        irq = 16'h0008;
        tick(3);
        do_ack(v);
        check(v == 4'd3, "R7 nested ack", v, 3);
        check(pri_isr == 8'h28, "R7 two in service", pri_isr, 8'h28);
        irq = '0;
        eoi(1'b0, 1'b1);
        check(pri_isr == 8'h28 && sec_isr == 8'h00, "R7 empty unit eoi",
              {pri_isr, sec_isr}, 16'h2800);
        eoi(1'b1, 1'b0);
        check(pri_isr == 8'h20, "R7 top cleared first", pri_isr, 8'h20);
        eoi(1'b1, 1'b0);
        check(pri_isr == 8'h00, "R7 second clear", pri_isr, 0);
        eoi(1'b1, 1'b0);
        check(pri_isr == 8'h00, "R7 no-op eoi", pri_isr, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule